// File: doc/BRIEF.md
# Audio Sample Queue with Threshold Service Request

This block is a small first-in first-out queue for audio samples. A serial audio interface uses four copies of it: the left and right channels on both the transmit path and the receive path. Software or a DMA engine writes samples into the transmit copies, and the serializer reads them out. The deserializer fills the receive copies, and software or DMA drains them. All ports share one clock.

Each copy compares its fill level against a programmable threshold. It raises a level-sensitive service request, which can be wired to an interrupt line or to a DMA request line. The direction of the comparison is fixed at elaboration by a direction parameter. A transmit queue asks for data when it runs low, and a receive queue asks to be drained when it fills up.

Each copy also keeps one sticky error flag. On a transmit queue the flag records an underrun, which is a read while empty. On a receive queue it records an overrun, which is a write while full. The flag has its own interrupt enable and is cleared by a write-one-to-clear strobe. A flush input empties the queue in one clock.

Top module: `afifo_chan`

## Requirements
- R1: After reset the queue is empty: `empty`=1, `full`=0, `level`=0, `rd_data`=0, `err_flag`=0 and `err_irq`=0.
- R2: Words leave in the order they were written. `rd_data` always shows the oldest stored word without a clock. A read strobe removes that word at the next rising edge.
- R3: `level` counts the stored words, from 0 up to DEPTH. `full` is 1 exactly when `level`=DEPTH and `empty` is 1 exactly when `level`=0. A read and a write accepted in the same cycle leave `level` unchanged.
- R4: A write while `full`=1 is discarded. The stored words, their order and `level` are unchanged.
- R5: A read while `empty`=1 returns `rd_data`=0 and does not move the read position. A word written afterwards is the next word read.
- R6: In a transmit queue (DIR=DIR_TX), `req` = `req_en` AND (`level` <= `thresh`).
- R7: In a receive queue (DIR=DIR_RX), `req` = `req_en` AND (`level` >= `thresh`).
- R8: In a transmit queue, a read while empty sets `err_flag` at the next edge. In a receive queue, a write while full sets it. An empty read on a receive queue does not set it, and neither does a full write on a transmit queue.
- R9: `err_flag` stays set until a cycle in which `err_clr`=1 and no new error event occurs. When a new event and `err_clr` fall in the same cycle, the flag stays set.
- R10: `err_irq` = `err_flag` AND `err_en`. `err_en` has no effect on whether `err_flag` is set or held.
- R11: When `flush`=1, the queue is empty with `level`=0 at the next edge. A read, write or error event in the same cycle has no effect.
- R12: All DATA_W bits of a stored word come back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Empty the queue at the next edge |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Sample to store |
| rd_en | input | 1 | Read strobe, removes the oldest word |
| rd_data | output | DATA_W | Oldest stored word, or 0 when empty |
| thresh | input | LVL_W | Service request threshold |
| req_en | input | 1 | Service request enable |
| err_en | input | 1 | Error interrupt enable |
| err_clr | input | 1 | Write-one-to-clear strobe for the error flag |
| empty | output | 1 | No word stored |
| full | output | 1 | DEPTH words stored |
| level | output | LVL_W | Number of stored words |
| req | output | 1 | Threshold service request |
| err_flag | output | 1 | Sticky underrun (transmit) or overrun (receive) flag |
| err_irq | output | 1 | Error flag gated by its enable |

## Verification
The bench builds two copies with DATA_W=24 and DEPTH=8, so LVL_W=4. One copy has DIR=DIR_TX and the other DIR=DIR_RX, which exercises both generate variants of the request compare and both error-event sources. With only eight slots, a short sequence fills the queue completely, wraps both pointers past the last slot, and hits the full and empty boundaries. The 4-bit threshold also reaches the values 0 and 8, where the request becomes the always-on or the full-only case.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

   typedef enum logic {
      DIR_TX = 1'b0,
      DIR_RX = 1'b1
   } fifo_dir_e;

   function automatic int lvl_width(input int depth);
      return $clog2(depth + 1);
   endfunction

endpackage

// File: rtl/afifo_store.sv
module afifo_store
   import afifo_pkg::*;
#(
   parameter fifo_dir_e DIR    = DIR_TX,
   parameter int        DATA_W = 24,
   parameter int        DEPTH  = 8,
   parameter int        LVL_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic [LVL_W-1:0]  level_o,
   output logic              empty_o,
   output logic              full_o,
   output logic              err_evt_o
);

   localparam int PTR_W = $clog2(DEPTH);

   logic [DATA_W-1:0] slots [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic [LVL_W-1:0]  count;
   logic              wr_ok, rd_ok;

   assign full_o  = (count == LVL_W'(DEPTH));
   assign empty_o = (count == '0);
   assign wr_ok   = wr_en & ~full_o & ~flush;
   assign rd_ok   = rd_en & ~empty_o & ~flush;
   assign level_o = count;
   assign rd_data = empty_o ? '0 : slots[rd_ptr];

   generate
      if (DIR == DIR_TX) begin : g_evt_under
         assign err_evt_o = rd_en & empty_o & ~flush;
      end else begin : g_evt_over
         assign err_evt_o = wr_en & full_o & ~flush;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
      end else if (wr_ok) begin
         slots[wr_ptr] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
         if (rd_ok) rd_ptr <= rd_ptr + 1'b1;
         case ({wr_ok, rd_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      count <= LVL_W'(DEPTH));

   assert_full_write_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && wr_en && !rd_en && !flush) |=> (full_o && $stable(rd_data)));

   assert_empty_read_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (empty_o && rd_en && !wr_en && !flush) |=> empty_o);

   assert_flush_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (empty_o && level_o == '0));

endmodule

// File: rtl/afifo_req.sv
module afifo_req
   import afifo_pkg::*;
#(
   parameter fifo_dir_e DIR   = DIR_TX,
   parameter int        LVL_W = 4
) (
   input  logic [LVL_W-1:0] level_i,
   input  logic [LVL_W-1:0] thresh,
   input  logic             req_en,
   output logic             req_o
);

   logic hit;

   generate
      if (DIR == DIR_TX) begin : g_low_water
         assign hit = (level_i <= thresh);
      end else begin : g_high_water
         assign hit = (level_i >= thresh);
      end
   endgenerate

   assign req_o = req_en & hit;

endmodule

// File: rtl/afifo_err.sv
module afifo_err (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_i,
   input  logic err_clr,
   input  logic err_en,
   output logic flag_o,
   output logic irq_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_o <= 1'b0;
      else if (evt_i)   flag_o <= 1'b1;
      else if (err_clr) flag_o <= 1'b0;
   end

   assign irq_o = flag_o & err_en;

   assert_event_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i |=> flag_o);

   assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !err_clr) |=> flag_o);

endmodule

// File: rtl/afifo_chan.sv
module afifo_chan
   import afifo_pkg::*;
#(
   parameter fifo_dir_e DIR    = DIR_TX,
   parameter int        DATA_W = 24,
   parameter int        DEPTH  = 8,
   parameter int        LVL_W  = lvl_width(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   input  logic [LVL_W-1:0]  thresh,
   input  logic              req_en,
   input  logic              err_en,
   input  logic              err_clr,
   output logic              empty,
   output logic              full,
   output logic [LVL_W-1:0]  level,
   output logic              req,
   output logic              err_flag,
   output logic              err_irq
);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("afifo_chan: DEPTH must be a power of two, at least 2");
      end
      if (DATA_W < 8 || DATA_W > 32) begin : g_bad_width
         $error("afifo_chan: DATA_W must lie between 8 and 32");
      end
      if (LVL_W < $clog2(DEPTH + 1)) begin : g_bad_lvl
         $error("afifo_chan: LVL_W too narrow for DEPTH");
      end
   endgenerate

   logic err_evt;

   afifo_store #(
      .DIR(DIR), .DATA_W(DATA_W), .DEPTH(DEPTH), .LVL_W(LVL_W)
   ) store_i (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data),
      .level_o(level), .empty_o(empty), .full_o(full),
      .err_evt_o(err_evt)
   );

   afifo_req #(
      .DIR(DIR), .LVL_W(LVL_W)
   ) req_i (
      .level_i(level), .thresh(thresh), .req_en(req_en), .req_o(req)
   );

   afifo_err err_i (
      .clk(clk), .rst_n(rst_n), .evt_i(err_evt),
      .err_clr(err_clr), .err_en(err_en),
      .flag_o(err_flag), .irq_o(err_irq)
   );

endmodule

// File: tb/afifo_chan_tb_top.sv
module afifo_chan_tb_top;
   import afifo_pkg::*;

   localparam int DW = 24;
   localparam int LW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   // transmit copy
   logic          t_fl = 0, t_wr = 0, t_rd = 0, t_ren = 1, t_een = 0, t_clr = 0;
   logic [DW-1:0] t_wd = '0, t_rdat;
   logic [LW-1:0] t_thr = 4'd2, t_lvl;
   logic          t_emp, t_full, t_req, t_flag, t_irq;
   // receive copy
   logic          r_fl = 0, r_wr = 0, r_rd = 0, r_ren = 1, r_een = 1, r_clr = 0;
   logic [DW-1:0] r_wd = '0, r_rdat;
   logic [LW-1:0] r_thr = 4'd3, r_lvl;
   logic          r_emp, r_full, r_req, r_flag, r_irq;

   afifo_chan #(.DIR(DIR_TX), .DATA_W(DW), .DEPTH(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .flush(t_fl), .wr_en(t_wr), .wr_data(t_wd),
      .rd_en(t_rd), .rd_data(t_rdat), .thresh(t_thr), .req_en(t_ren),
      .err_en(t_een), .err_clr(t_clr), .empty(t_emp), .full(t_full),
      .level(t_lvl), .req(t_req), .err_flag(t_flag), .err_irq(t_irq));

   afifo_chan #(.DIR(DIR_RX), .DATA_W(DW), .DEPTH(8)) dut_rx_i (
      .clk(clk), .rst_n(rst_n), .flush(r_fl), .wr_en(r_wr), .wr_data(r_wd),
      .rd_en(r_rd), .rd_data(r_rdat), .thresh(r_thr), .req_en(r_ren),
      .err_en(r_een), .err_clr(r_clr), .empty(r_emp), .full(r_full),
      .level(r_lvl), .req(r_req), .err_flag(r_flag), .err_irq(r_irq));

   int n_run = 0, n_fail = 0;

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
      end
   endtask

   task automatic tx_op(input logic w, input logic r, input logic [DW-1:0] d,
                        input logic fl, input logic cl);
      @(negedge clk);
      t_wr = w; t_rd = r; t_wd = d; t_fl = fl; t_clr = cl;
      @(posedge clk); #1;
      t_wr = 0; t_rd = 0; t_fl = 0; t_clr = 0;
   endtask

   task automatic rx_op(input logic w, input logic r, input logic [DW-1:0] d,
                        input logic cl);
      @(negedge clk);
      r_wr = w; r_rd = r; r_wd = d; r_clr = cl;
      @(posedge clk); #1;
      r_wr = 0; r_rd = 0; r_clr = 0;
   endtask

   typedef struct packed {
      logic          wr;
      logic          rd;
      logic [DW-1:0] d;
      logic [LW-1:0] thr;
      logic [LW-1:0] lvl;
      logic          emp;
      logic          full;
      logic          req;
      logic [DW-1:0] head;
   } vec_t;

   localparam int NV = 21;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 1'b0, 24'hA00001, 4'd2, 4'd1, 1'b0, 1'b0, 1'b1, 24'hA00001},
      '{1'b1, 1'b0, 24'hA00002, 4'd2, 4'd2, 1'b0, 1'b0, 1'b1, 24'hA00001},
      '{1'b1, 1'b0, 24'hA00003, 4'd2, 4'd3, 1'b0, 1'b0, 1'b0, 24'hA00001},
      '{1'b0, 1'b1, 24'h000000, 4'd2, 4'd2, 1'b0, 1'b0, 1'b1, 24'hA00002},
      '{1'b1, 1'b1, 24'hA00004, 4'd2, 4'd2, 1'b0, 1'b0, 1'b1, 24'hA00003},
      '{1'b1, 1'b0, 24'hA00005, 4'd2, 4'd3, 1'b0, 1'b0, 1'b0, 24'hA00003},
      '{1'b1, 1'b0, 24'hA00006, 4'd2, 4'd4, 1'b0, 1'b0, 1'b0, 24'hA00003},
      '{1'b1, 1'b0, 24'hA00007, 4'd5, 4'd5, 1'b0, 1'b0, 1'b1, 24'hA00003},
      '{1'b1, 1'b0, 24'hA00008, 4'd5, 4'd6, 1'b0, 1'b0, 1'b0, 24'hA00003},
      '{1'b1, 1'b0, 24'hA00009, 4'd2, 4'd7, 1'b0, 1'b0, 1'b0, 24'hA00003},
      '{1'b1, 1'b0, 24'hA0000A, 4'd2, 4'd8, 1'b0, 1'b1, 1'b0, 24'hA00003},
      '{1'b1, 1'b0, 24'hB00000, 4'd8, 4'd8, 1'b0, 1'b1, 1'b1, 24'hA00003},
      '{1'b0, 1'b1, 24'h000000, 4'd2, 4'd7, 1'b0, 1'b0, 1'b0, 24'hA00004},
      '{1'b0, 1'b1, 24'h000000, 4'd2, 4'd6, 1'b0, 1'b0, 1'b0, 24'hA00005},
      '{1'b0, 1'b1, 24'h000000, 4'd2, 4'd5, 1'b0, 1'b0, 1'b0, 24'hA00006},
      '{1'b0, 1'b1, 24'h000000, 4'd2, 4'd4, 1'b0, 1'b0, 1'b0, 24'hA00007},
      '{1'b0, 1'b1, 24'h000000, 4'd2, 4'd3, 1'b0, 1'b0, 1'b0, 24'hA00008},
      '{1'b0, 1'b1, 24'h000000, 4'd2, 4'd2, 1'b0, 1'b0, 1'b1, 24'hA00009},
      '{1'b0, 1'b1, 24'h000000, 4'd2, 4'd1, 1'b0, 1'b0, 1'b1, 24'hA0000A},
      '{1'b1, 1'b1, 24'hC00001, 4'd2, 4'd1, 1'b0, 1'b0, 1'b1, 24'hC00001},
      '{1'b0, 1'b1, 24'h000000, 4'd2, 4'd0, 1'b1, 1'b0, 1'b1, 24'h000000}
   };

   initial begin : wdog
      #2000000;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk("R1 tx level", 32'(t_lvl), 0);
      chk("R1 tx empty", 32'(t_emp), 1);
      chk("R1 tx full", 32'(t_full), 0);
      chk("R1 tx rd_data", 32'(t_rdat), 0);
      chk("R1 tx flag", 32'(t_flag), 0);
      chk("R1 tx irq", 32'(t_irq), 0);
      chk("R6 tx req at level 0", 32'(t_req), 1);
      chk("R7 rx req at level 0", 32'(r_req), 0);
      @(negedge clk); rst_n = 1'b1;

      // table walk: R2 order, R3 level, R4 drop on full, R6 low-water request
      for (int k = 0; k < NV; k++) begin
         @(negedge clk); t_thr = VEC[k].thr;
         tx_op(VEC[k].wr, VEC[k].rd, VEC[k].d, 1'b0, 1'b0);
         chk($sformatf("R3 level v%0d", k), 32'(t_lvl), 32'(VEC[k].lvl));
         chk($sformatf("R3 empty v%0d", k), 32'(t_emp), 32'(VEC[k].emp));
         chk($sformatf("R3 full v%0d", k), 32'(t_full), 32'(VEC[k].full));
         chk($sformatf("R6 req v%0d", k), 32'(t_req), 32'(VEC[k].req));
         chk($sformatf("R2 R4 head v%0d", k), 32'(t_rdat), 32'(VEC[k].head));
      end
      chk("R8 tx full write sets no flag", 32'(t_flag), 0);

      // R5 / R8 underrun, R10 enable gating
      tx_op(1'b0, 1'b1, '0, 1'b0, 1'b0);
      chk("R5 empty read data", 32'(t_rdat), 0);
      chk("R8 tx underrun flag", 32'(t_flag), 1);
      chk("R10 irq masked", 32'(t_irq), 0);
      @(negedge clk); t_een = 1'b1; #1;
      chk("R10 irq enabled", 32'(t_irq), 1);
      repeat (3) @(posedge clk);
      #1;
      chk("R9 flag held", 32'(t_flag), 1);
      tx_op(1'b1, 1'b0, 24'hD00001, 1'b0, 1'b0);
      chk("R5 pointer held", 32'(t_rdat), 32'h00D00001);
      chk("R5 level after", 32'(t_lvl), 1);
      tx_op(1'b0, 1'b0, '0, 1'b0, 1'b1);
      chk("R9 clear", 32'(t_flag), 0);
      chk("R10 irq after clear", 32'(t_irq), 0);
      tx_op(1'b0, 1'b1, '0, 1'b0, 1'b0);
      tx_op(1'b0, 1'b1, '0, 1'b0, 1'b1);
      chk("R9 set wins over clear", 32'(t_flag), 1);
      tx_op(1'b0, 1'b0, '0, 1'b0, 1'b1);

      // R11 flush
      tx_op(1'b1, 1'b0, 24'hE00001, 1'b0, 1'b0);
      tx_op(1'b1, 1'b0, 24'hE00002, 1'b0, 1'b0);
      tx_op(1'b1, 1'b0, 24'hE00003, 1'b0, 1'b0);
      tx_op(1'b1, 1'b1, 24'hE00004, 1'b1, 1'b0);
      chk("R11 flush level", 32'(t_lvl), 0);
      chk("R11 flush empty", 32'(t_emp), 1);
      tx_op(1'b0, 1'b1, '0, 1'b1, 1'b0);
      chk("R11 flush blocks event", 32'(t_flag), 0);
      tx_op(1'b1, 1'b0, 24'hF00001, 1'b0, 1'b0);
      chk("R11 after flush head", 32'(t_rdat), 32'h00F00001);
      @(negedge clk); t_ren = 1'b0; #1;
      chk("R6 req disabled", 32'(t_req), 0);

      // receive copy: R7 high-water request
      rx_op(1'b1, 1'b0, 24'h100001, 1'b0);
      rx_op(1'b1, 1'b0, 24'h100002, 1'b0);
      chk("R7 level 2 below", 32'(r_req), 0);
      rx_op(1'b1, 1'b0, 24'h100003, 1'b0);
      chk("R7 level 3 at", 32'(r_req), 1);
      @(negedge clk); r_ren = 1'b0; #1;
      chk("R7 req disabled", 32'(r_req), 0);
      @(negedge clk); r_ren = 1'b1;
      for (int k = 4; k <= 8; k++) rx_op(1'b1, 1'b0, 24'h100000 + 24'(k), 1'b0);
      chk("R3 rx full", 32'(r_full), 1);
      chk("R8 rx no flag yet", 32'(r_flag), 0);
      rx_op(1'b1, 1'b0, 24'hFFFFFF, 1'b0);
      chk("R8 rx overrun flag", 32'(r_flag), 1);
      chk("R10 rx irq", 32'(r_irq), 1);
      chk("R4 rx level kept", 32'(r_lvl), 8);
      chk("R4 rx head kept", 32'(r_rdat), 32'h00100001);
      for (int k = 1; k <= 8; k++) begin
         chk($sformatf("R2 rx order %0d", k), 32'(r_rdat), 32'h00100000 + 32'(k));
         rx_op(1'b0, 1'b1, '0, 1'b0);
      end
      chk("R4 rx drained", 32'(r_emp), 1);
      rx_op(1'b0, 1'b0, '0, 1'b1);
      rx_op(1'b0, 1'b1, '0, 1'b0);
      chk("R8 rx empty read no flag", 32'(r_flag), 0);
      rx_op(1'b1, 1'b0, 24'hA5C3F0, 1'b0);
      chk("R12 full width", 32'(r_rdat), 32'h00A5C3F0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule